// File: doc/BRIEF.md
# Physical Memory Access Permission Checker

This block decides whether one memory access may go ahead under a set of physical protection regions. Each region arrives already decoded as an inclusive byte range (low and high bound) together with its configuration byte. The checker takes the access address, a size code, the requested read/write/execute set and whether the hart runs in machine mode. It finds the lowest-numbered enabled region that the access touches and grants the access only when the permissions of that region cover the whole request. When no region matches, a fallback policy applies.

Two security control bits change the outcome. The lockdown bit replaces the plain permission rule with fixed sixteen-row tables indexed by {lock, R, W, X}, one table for machine mode and one for the lower modes. The whitelist bit makes the no-match fallback deny everything, machine mode included. The decision is combinational and is registered once, so the grant and the permitted mask appear one clock after the inputs are sampled.

Top module: `pmp_perm_check`

## Requirements
- R1: While reset is asserted and directly after it, `grant` is 0 and `grant_perm` is 3'b000.
- R2: The outputs reflect the inputs sampled at the previous rising clock edge and hold between edges.
- R3: Regions are examined from index 0 upward; the first enabled region that contains either the first or the last byte of the access alone decides the result, and higher regions are ignored.
- R4: If exactly one of the first and last byte lies inside the deciding region, the access is denied with `grant_perm` = 3'b000.
- R5: The last byte is `req_addr + 2**req_size - 1` (modulo 2**ADDR_W), with `req_size` codes 0..3 meaning 1, 2, 4 and 8 bytes.
- R6: Permission bits use bit 0 = R, bit 1 = W, bit 2 = X in `req_perm`, `grant_perm` and config bits [2:0]; config bit 7 is the lock, bits [4:3] the match mode. With lockdown clear, a fully contained match in machine mode on an unlocked region permits RWX; otherwise it permits the region's R, W, X bits.
- R7: With lockdown set in machine mode, index {L,R,W,X} 0,1,4,5,6,7,8 permits nothing; 2,3,14 permit RW; 9,10 permit X; 11,13 permit RX; 12,15 permit R.
- R8: With lockdown set outside machine mode, index 0,8,9,12,13,14 permits nothing; 1,10,11 permit X; 2,4,15 permit R; 3,6 permit RW; 5 permits RX; 7 permits RWX.
- R9: `grant` is 1 exactly when every requested bit is in `grant_perm`.
- R10: With no match and whitelist set, the access is denied with `grant_perm` = 3'b000.
- R11: With no match, whitelist clear and lockdown set, a machine-mode request without X is granted with `grant_perm` = RW; every other request is denied with 3'b000.
- R12: With no match and both control bits clear, machine mode is granted RWX; other modes are denied with 3'b000.
- R13: A region whose match-mode field is 0 never matches; with all regions in that state the no-match fallback applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_addr | input | ADDR_W | Byte address of the first byte accessed |
| req_size | input | 2 | Size code: access covers 2**req_size bytes |
| req_perm | input | 3 | Requested permissions {X,W,R} |
| req_mach | input | 1 | 1 when the access is made in machine mode |
| sec_lockdown | input | 1 | Lockdown control bit: table-driven permissions |
| sec_whitelist | input | 1 | Whitelist control bit: deny when nothing matches |
| rgn_lo | input | NUM_RGN*ADDR_W | Inclusive low bound of each region, region 0 in the lowest slice |
| rgn_hi | input | NUM_RGN*ADDR_W | Inclusive high bound of each region |
| rgn_cfg | input | NUM_RGN*8 | Configuration byte of each region |
| grant | output | 1 | Registered decision: access permitted |
| grant_perm | output | 3 | Registered permitted set {X,W,R} |

## Verification
Every result of this block is due exactly one rising edge after the inputs it depends on were sampled. The bench changes inputs on the falling edge, lets one rising edge pass and compares both outputs on the next falling edge, so each vector is judged against the edge that captured it. For the latency requirement it also changes inputs and looks at the outputs before the next rising edge, where the previous decision must still be present.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

   typedef logic [2:0] perm_t;

   localparam perm_t PERM_NONE = 3'b000;
   localparam perm_t PERM_R    = 3'b001;
   localparam perm_t PERM_W    = 3'b010;
   localparam perm_t PERM_X    = 3'b100;

   localparam int CFG_W       = 8;
   localparam int CFG_LOCK    = 7;
   localparam int CFG_MODE_LO = 3;
   localparam int CFG_MODE_HI = 4;

   // Fixed permission tables used while lockdown is active.
   // Index is {lock, R, W, X}.
   function automatic perm_t lockdown_perm(input logic mach, input logic [3:0] idx);
      perm_t p;
      p = PERM_NONE;
      if (mach) begin
         case (idx)
            4'd2, 4'd3, 4'd14: p = PERM_R | PERM_W;
            4'd9, 4'd10:       p = PERM_X;
            4'd11, 4'd13:      p = PERM_R | PERM_X;
            4'd12, 4'd15:      p = PERM_R;
            default:           p = PERM_NONE;
         endcase
      end else begin
         case (idx)
            4'd1, 4'd10, 4'd11: p = PERM_X;
            4'd2, 4'd4, 4'd15:  p = PERM_R;
            4'd3, 4'd6:         p = PERM_R | PERM_W;
            4'd5:               p = PERM_R | PERM_X;
            4'd7:               p = PERM_R | PERM_W | PERM_X;
            default:            p = PERM_NONE;
         endcase
      end
      return p;
   endfunction

endpackage

// File: rtl/pmp_region_cmp.sv
module pmp_region_cmp #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] lo,
   input  logic [ADDR_W-1:0] hi,
   input  logic [ADDR_W-1:0] first_b,
   input  logic [ADDR_W-1:0] last_b,
   input  logic [1:0]        mode,
   output logic              enabled,
   output logic              first_in,
   output logic              last_in
);

   assign enabled  = (mode != 2'b00);
   assign first_in = (first_b >= lo) && (first_b <= hi);
   assign last_in  = (last_b  >= lo) && (last_b  <= hi);

endmodule

// File: rtl/pmp_first_pick.sv
module pmp_first_pick #(
   parameter int NUM = 4
) (
   input  logic [NUM-1:0] touch,
   output logic [NUM-1:0] sel
);

   logic [NUM:0] seen;

   assign seen[0] = 1'b0;

   for (genvar i = 0; i < NUM; i++) begin : g_chain
      assign seen[i+1] = seen[i] | touch[i];
      assign sel[i]    = touch[i] & ~seen[i];
   end

endmodule

// File: rtl/pmp_rule_perm.sv
module pmp_rule_perm
   import pmp_chk_pkg::*;
#(
   parameter bit ENHANCED = 1'b1
) (
   input  logic  lock,
   input  perm_t rwx,
   input  logic  mach,
   input  logic  lockdown,
   output perm_t perm
);

   perm_t plain_perm;

   assign plain_perm = (mach && !lock) ? (PERM_R | PERM_W | PERM_X) : rwx;

   if (ENHANCED) begin : g_enh
      always_comb begin
         if (lockdown) perm = lockdown_perm(mach, {lock, rwx[0], rwx[1], rwx[2]});
         else          perm = plain_perm;
      end
   end else begin : g_plain
      logic lockdown_unused;
      assign lockdown_unused = lockdown;
      assign perm = plain_perm;
   end

endmodule

// File: rtl/pmp_perm_check.sv
module pmp_perm_check
   import pmp_chk_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int NUM_RGN  = 4,
   parameter bit ENHANCED = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          req_addr,
   input  logic [1:0]                 req_size,
   input  logic [2:0]                 req_perm,
   input  logic                       req_mach,
   input  logic                       sec_lockdown,
   input  logic                       sec_whitelist,
   input  logic [NUM_RGN*ADDR_W-1:0]  rgn_lo,
   input  logic [NUM_RGN*ADDR_W-1:0]  rgn_hi,
   input  logic [NUM_RGN*CFG_W-1:0]   rgn_cfg,
   output logic                       grant,
   output logic [2:0]                 grant_perm
);

   localparam int SPAN_W = 4;

   initial begin : elab_chk
      if (NUM_RGN < 1)  $fatal(1, "pmp_perm_check: NUM_RGN must be at least 1");
      if (ADDR_W < 8)   $fatal(1, "pmp_perm_check: ADDR_W must be at least 8");
   end

   logic [ADDR_W-1:0]  last_b;
   logic [NUM_RGN-1:0] en_v, fin_v, lin_v, touch_v, win_sel;
   logic [NUM_RGN-1:0] lock_v;
   perm_t              rwx_v [NUM_RGN];
   logic               cfg_unused;

   assign last_b = req_addr + ADDR_W'((SPAN_W'(1) << req_size) - SPAN_W'(1));

   for (genvar i = 0; i < NUM_RGN; i++) begin : g_rgn
      pmp_region_cmp #(.ADDR_W(ADDR_W)) u_cmp (
         .lo      (rgn_lo[i*ADDR_W +: ADDR_W]),
         .hi      (rgn_hi[i*ADDR_W +: ADDR_W]),
         .first_b (req_addr),
         .last_b  (last_b),
         .mode    (rgn_cfg[i*CFG_W+CFG_MODE_LO +: 2]),
         .enabled (en_v[i]),
         .first_in(fin_v[i]),
         .last_in (lin_v[i])
      );
      assign touch_v[i] = en_v[i] & (fin_v[i] | lin_v[i]);
      assign lock_v[i]  = rgn_cfg[i*CFG_W + CFG_LOCK];
      assign rwx_v[i]   = rgn_cfg[i*CFG_W +: 3];
   end

   always_comb begin
      cfg_unused = 1'b0;
      for (int i = 0; i < NUM_RGN; i++) cfg_unused = cfg_unused ^ (^rgn_cfg[i*CFG_W+5 +: 2]);
   end

   pmp_first_pick #(.NUM(NUM_RGN)) u_pick (
      .touch(touch_v),
      .sel  (win_sel)
   );

   // And-or multiplex of the deciding region
   logic  win_lock, win_part, any_hit;
   perm_t win_rwx;

   always_comb begin
      win_lock = 1'b0;
      win_rwx  = PERM_NONE;
      win_part = 1'b0;
      for (int i = 0; i < NUM_RGN; i++) begin
         win_lock = win_lock | (win_sel[i] & lock_v[i]);
         win_rwx  = win_rwx  | (win_sel[i] ? rwx_v[i] : PERM_NONE);
         win_part = win_part | (win_sel[i] & (fin_v[i] ^ lin_v[i]));
      end
   end

   assign any_hit = |win_sel;

   perm_t match_perm;

   pmp_rule_perm #(.ENHANCED(ENHANCED)) u_rule (
      .lock    (win_lock),
      .rwx     (win_rwx),
      .mach    (req_mach),
      .lockdown(sec_lockdown),
      .perm    (match_perm)
   );

   // Fallback when nothing matches
   logic  dflt_ok;
   perm_t dflt_perm;
   logic  ld_eff, wl_eff;

   assign ld_eff = ENHANCED & sec_lockdown;
   assign wl_eff = ENHANCED & sec_whitelist;

   always_comb begin
      if (wl_eff) begin
         dflt_ok   = 1'b0;
         dflt_perm = PERM_NONE;
      end else if (ld_eff) begin
         dflt_ok   = req_mach && !req_perm[2];
         dflt_perm = dflt_ok ? (PERM_R | PERM_W) : PERM_NONE;
      end else begin
         dflt_ok   = req_mach;
         dflt_perm = req_mach ? (PERM_R | PERM_W | PERM_X) : PERM_NONE;
      end
   end

   logic  nxt_grant;
   perm_t nxt_perm;

   always_comb begin
      if (!any_hit) begin
         nxt_grant = dflt_ok;
         nxt_perm  = dflt_perm;
      end else if (win_part) begin
         nxt_grant = 1'b0;
         nxt_perm  = PERM_NONE;
      end else begin
         nxt_perm  = match_perm;
         nxt_grant = ((req_perm & match_perm) == req_perm);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant      <= 1'b0;
         grant_perm <= PERM_NONE;
      end else begin
         grant      <= nxt_grant;
         grant_perm <= nxt_perm;
      end
   end

   // Assertions
   p_reset_r1: assert property (@(posedge clk) !rst_n |=> (grant == 1'b0 && grant_perm == 3'b000));

   p_pick_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(win_sel));

   p_pick_lowest_r3: assert property (@(posedge clk) disable iff (!rst_n)
      any_hit |-> (((win_sel - NUM_RGN'(1)) & touch_v) == '0));

   p_pick_any_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (|touch_v) == any_hit);

   p_partial_deny_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (any_hit && win_part) |=> (!grant && grant_perm == 3'b000));

   p_grant_subset_r9: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> (($past(req_perm) & ~grant_perm) == 3'b000));

   p_whitelist_deny_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_hit && wl_eff) |=> (!grant && grant_perm == 3'b000));

   p_lockdown_exec_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_hit && ld_eff && !wl_eff && req_perm[2]) |=> !grant);

   p_user_default_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_hit && !req_mach) |=> !grant);

endmodule

// File: tb/pmp_perm_check_tb.sv
`timescale 1ns/1ps
module pmp_perm_check_tb;

   localparam int AW = 32;
   localparam int NR = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [AW-1:0]    req_addr = '0;
   logic [1:0]       req_size = '0;
   logic [2:0]       req_perm = '0;
   logic             req_mach = 1'b0;
   logic             sec_lockdown = 1'b0;
   logic             sec_whitelist = 1'b0;
   logic [AW-1:0]    lo_a  [NR];
   logic [AW-1:0]    hi_a  [NR];
   logic [7:0]       cfg_a [NR];
   logic [NR*AW-1:0] rgn_lo, rgn_hi;
   logic [NR*8-1:0]  rgn_cfg;
   logic             grant;
   logic [2:0]       grant_perm;

   always_comb begin
      for (int i = 0; i < NR; i++) begin
         rgn_lo[i*AW +: AW] = lo_a[i];
         rgn_hi[i*AW +: AW] = hi_a[i];
         rgn_cfg[i*8 +: 8]  = cfg_a[i];
      end
   end

   pmp_perm_check #(.ADDR_W(AW), .NUM_RGN(NR)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_size(req_size),
      .req_perm(req_perm), .req_mach(req_mach), .sec_lockdown(sec_lockdown),
      .sec_whitelist(sec_whitelist), .rgn_lo(rgn_lo), .rgn_hi(rgn_hi),
      .rgn_cfg(rgn_cfg), .grant(grant), .grant_perm(grant_perm)
   );

   int n_chk = 0;
   int n_fail = 0;

   // Tables from R7 / R8
   function automatic logic [2:0] tab_m(input int idx);
      case (idx)
         2, 3, 14: return 3'b011;
         9, 10:    return 3'b100;
         11, 13:   return 3'b101;
         12, 15:   return 3'b001;
         default:  return 3'b000;
      endcase
   endfunction

   function automatic logic [2:0] tab_u(input int idx);
      case (idx)
         1, 10, 11: return 3'b100;
         2, 4, 15:  return 3'b001;
         3, 6:      return 3'b011;
         5:         return 3'b101;
         7:         return 3'b111;
         default:   return 3'b000;
      endcase
   endfunction

   function automatic void model(output logic g, output logic [2:0] p, output string tag);
      logic [AW-1:0] last;
      logic f, l;
      int idx;
      last = req_addr + (AW'(1) << req_size) - AW'(1);
      for (int i = 0; i < NR; i++) begin
         if (cfg_a[i][4:3] != 2'b00) begin
            f = (req_addr >= lo_a[i]) && (req_addr <= hi_a[i]);
            l = (last >= lo_a[i]) && (last <= hi_a[i]);
            if (f != l) begin g = 1'b0; p = 3'b000; tag = "R4"; return; end
            if (f && l) begin
               idx = {cfg_a[i][7], cfg_a[i][0], cfg_a[i][1], cfg_a[i][2]};
               if (sec_lockdown) begin
                  p = req_mach ? tab_m(idx) : tab_u(idx);
                  tag = req_mach ? "R7" : "R8";
               end else begin
                  p = (req_mach && !cfg_a[i][7]) ? 3'b111 : cfg_a[i][2:0];
                  tag = "R6";
               end
               g = ((req_perm & p) == req_perm);
               return;
            end
         end
      end
      if (sec_whitelist) begin g = 1'b0; p = 3'b000; tag = "R10"; end
      else if (sec_lockdown) begin
         g = req_mach && !req_perm[2]; p = g ? 3'b011 : 3'b000; tag = "R11";
      end else begin
         g = req_mach; p = req_mach ? 3'b111 : 3'b000; tag = "R12";
      end
   endfunction

   task automatic cmp(input string sect, input logic eg, input logic [2:0] ep, input string mt);
      n_chk++;
      if (grant !== eg || grant_perm !== ep) begin
         n_fail++;
         $display("FAIL %s/%s addr=%h sz=%0d req=%b m=%b ld=%b wl=%b: got grant=%b perm=%b exp grant=%b perm=%b",
                  sect, mt, req_addr, req_size, req_perm, req_mach, sec_lockdown, sec_whitelist,
                  grant, grant_perm, eg, ep);
      end
   endtask

   // Drive on falling edge already done by caller; wait one rising edge, check at next falling edge
   task automatic run(input string sect);
      logic eg; logic [2:0] ep; string mt;
      model(eg, ep, mt);
      @(negedge clk);
      cmp(sect, eg, ep, mt);
   endtask

   task automatic clear_rgns();
      for (int i = 0; i < NR; i++) begin
         lo_a[i] = '0; hi_a[i] = '0; cfg_a[i] = 8'h00;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete, exp completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : stim
      logic eg; logic [2:0] ep; string mt;
      clear_rgns();
      repeat (3) @(negedge clk);
      // R1: reset state
      cmp("R1", 1'b0, 3'b000, "reset");
      rst_n = 1'b1;
      @(negedge clk);
      sec_whitelist = 1'b1; req_mach = 1'b1;
      @(negedge clk);
      cmp("R1", 1'b0, 3'b000, "post");

      // R6 R7 R8 R9: single region, full sweep of lock/RWX, modes, requests
      clear_rgns();
      lo_a[0] = 32'h0000_1000; hi_a[0] = 32'h0000_10FF;
      req_addr = 32'h0000_1010; req_size = 2'd2;
      for (int c = 0; c < 16; c++)
         for (int wl = 0; wl < 2; wl++)
            for (int ld = 0; ld < 2; ld++)
               for (int m = 0; m < 2; m++)
                  for (int r = 0; r < 8; r++) begin
                     cfg_a[0] = {c[3], 2'b00, 2'b01, c[0], c[1], c[2]};
                     sec_whitelist = wl[0]; sec_lockdown = ld[0];
                     req_mach = m[0]; req_perm = r[2:0];
                     run("R9");
                  end

      // R13 with R10 R11 R12: regions off yet covering the address, then enabled but elsewhere
      for (int pass = 0; pass < 2; pass++) begin
         for (int i = 0; i < NR; i++) begin
            lo_a[i] = (pass == 0) ? 32'h0 : 32'h0008_0000 + 32'(i) * 32'h100;
            hi_a[i] = (pass == 0) ? 32'hFFFF_FFFF : 32'h0008_00FF + 32'(i) * 32'h100;
            cfg_a[i] = (pass == 0) ? 8'h87 : 8'h0F;
         end
         req_addr = 32'h0000_4000; req_size = 2'd3;
         for (int wl = 0; wl < 2; wl++)
            for (int ld = 0; ld < 2; ld++)
               for (int m = 0; m < 2; m++)
                  for (int r = 0; r < 8; r++) begin
                     sec_whitelist = wl[0]; sec_lockdown = ld[0];
                     req_mach = m[0]; req_perm = r[2:0];
                     run((pass == 0) ? "R13" : "R12");
                  end
      end

      // R3 R4 R5: overlapping regions, addresses swept across every boundary
      clear_rgns();
      lo_a[0] = 32'h0000_2000; hi_a[0] = 32'h0000_20FF; cfg_a[0] = 8'h09;
      lo_a[1] = 32'h0000_1000; hi_a[1] = 32'h0000_1FFF; cfg_a[1] = 8'h0B;
      lo_a[2] = 32'h0000_1800; hi_a[2] = 32'h0000_18FF; cfg_a[2] = 8'h0C;
      lo_a[3] = 32'h0000_0000; hi_a[3] = 32'h0000_FFFF; cfg_a[3] = 8'h8F;
      sec_whitelist = 1'b0;
      for (int b = 0; b < 4; b++) begin
         logic [AW-1:0] base;
         base = (b == 0) ? 32'h0000_0FF0 : (b == 1) ? 32'h0000_17F0 :
                (b == 2) ? 32'h0000_18F0 : 32'h0000_1FF0;
         for (int off = 0; off < 34; off++)
            for (int sz = 0; sz < 4; sz++)
               for (int k = 0; k < 3; k++) begin
                  req_addr = base + 32'(off);
                  req_size = sz[1:0];
                  req_perm = (k == 0) ? 3'b001 : (k == 1) ? 3'b010 : 3'b100;
                  req_mach = off[0];
                  sec_lockdown = (off % 3 == 2);
                  run((b == 3) ? "R5" : "R3");
               end
      end

      // R2: result held until the next rising edge
      sec_lockdown = 1'b0; sec_whitelist = 1'b0;
      req_addr = 32'h0000_2004; req_size = 2'd0; req_perm = 3'b001; req_mach = 1'b0;
      model(eg, ep, mt);
      @(negedge clk);
      cmp("R2", eg, ep, mt);
      req_perm = 3'b010;
      #1;
      cmp("R2", eg, ep, "hold");
      run("R2");

      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule